// File: doc/BRIEF.md
# Serial Byte Collector with Even Parity

This block turns a qualified serial bit stream into bytes. On every clock edge where the qualifier input is high, one bit is taken from the serial input and placed in an internal shift register. The first bit taken becomes bit 0 of the byte, so the stream is least-significant-bit first. When the eighth qualified bit arrives, the finished byte is registered onto the parallel output. A one-cycle strobe marks it, and an even-parity bit computed over the same byte is registered with it.

Cycles with the qualifier low are simply skipped. A partly received byte waits across any number of such gaps. The parallel byte and its parity stay unchanged until the next byte completes. Because the bit counter wraps in the same cycle it completes a byte, a continuous stream yields one byte every eight cycles with no dead cycle between bytes.

Top module: `ser_byte_collector`

## Requirements
- R1: A synchronous active-high reset clears the parallel byte, the parity bit and the strobe to 0 and discards any partly received byte, so the next byte starts with a fresh first bit.
- R2: A serial bit is taken only on clock edges where `bit_vld_i` is 1. On edges where it is 0, the value on `bit_i` has no effect on any later byte.
- R3: Bits are assembled least-significant-bit first: the first accepted bit of a byte appears at `byte_o[0]` and the eighth at `byte_o[7]`.
- R4: `byte_vld_o` is 1 for exactly one cycle, starting in the cycle after the clock edge that accepts the eighth bit of a byte. It is never high in two consecutive cycles.
- R5: While `byte_vld_o` is 1, `byte_par_o` equals the XOR of all eight bits of `byte_o`. It is 1 exactly when the byte holds an odd number of ones, so the byte together with the parity bit always has an even count of ones.
- R6: Between strobes, `byte_o` and `byte_par_o` keep the values of the last completed byte.
- R7: Back-to-back bytes need no idle cycle: with `bit_vld_i` held at 1, every group of eight consecutive bits forms a byte, one strobe every eight cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| bit_i | input | 1 | Serial data bit |
| bit_vld_i | input | 1 | Qualifier: the bit on `bit_i` is taken at this edge |
| byte_o | output | 8 | Last completed byte, bit 0 received first |
| byte_vld_o | output | 1 | One-cycle strobe marking a newly completed byte |
| byte_par_o | output | 1 | Even-parity bit of `byte_o` |

## Verification
The properties assume that reset is held for at least one clock edge before the stream starts. They also assume that `bit_i` and `bit_vld_i` are settled before each rising edge, because the block only ever samples them at that edge. The stimulus changes inputs only on falling edges and holds reset for several cycles at the start. It drives the inverse of the wanted bit on `bit_i` during idle gaps, so any bit wrongly taken while the qualifier is low would corrupt a byte. It also cuts one byte short with a reset, to check that reset discards the partial byte.

// File: rtl/sbc_pkg.sv
package sbc_pkg;
    localparam int WORD_W = 8;
    localparam int CNT_W  = (WORD_W > 1) ? $clog2(WORD_W) : 1;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [CNT_W-1:0]  cnt_t;

    typedef struct packed {
        word_t data;
        logic  par;
    } result_t;

    localparam cnt_t CNT_LAST = cnt_t'(WORD_W - 1);

    function automatic logic even_par(input word_t w);
        return ^w;
    endfunction
endpackage

// File: rtl/sbc_bit_counter.sv
module sbc_bit_counter
    import sbc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic adv_i,
    output logic last_o
);
    cnt_t cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (adv_i) begin
            if (cnt_q == CNT_LAST) cnt_q <= '0;
            else                   cnt_q <= cnt_q + cnt_t'(1);
        end
    end

    assign last_o = adv_i && (cnt_q == CNT_LAST);
endmodule

// File: rtl/sbc_shifter.sv
module sbc_shifter
    import sbc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  shift_i,
    input  logic  bit_i,
    output word_t next_o
);
    word_t sh_q;

    // New bit enters at the top and moves down, so the first bit ends at bit 0.
    generate
        if (WORD_W > 1) begin : g_wide
            assign next_o = {bit_i, sh_q[WORD_W-1:1]};
        end else begin : g_single
            assign next_o = bit_i;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)          sh_q <= '0;
        else if (shift_i) sh_q <= next_o;
    end
endmodule

// File: rtl/sbc_result_reg.sv
module sbc_result_reg
    import sbc_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    load_i,
    input  word_t   word_i,
    output result_t res_o,
    output logic    vld_o
);
    result_t res_q;
    logic    vld_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
            vld_q <= 1'b0;
        end else begin
            vld_q <= load_i;
            if (load_i) begin
                res_q.data <= word_i;
                res_q.par  <= even_par(word_i);
            end
        end
    end

    assign res_o = res_q;
    assign vld_o = vld_q;
endmodule

// File: rtl/ser_byte_collector.sv
module ser_byte_collector
    import sbc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_i,
    input  logic              bit_vld_i,
    output logic [WORD_W-1:0] byte_o,
    output logic              byte_vld_o,
    output logic              byte_par_o
);
    logic    last_w;
    word_t   next_w;
    result_t res_w;

    sbc_bit_counter u_cnt (
        .clk    (clk),
        .rst    (rst),
        .adv_i  (bit_vld_i),
        .last_o (last_w)
    );

    sbc_shifter u_sh (
        .clk     (clk),
        .rst     (rst),
        .shift_i (bit_vld_i),
        .bit_i   (bit_i),
        .next_o  (next_w)
    );

    sbc_result_reg u_out (
        .clk    (clk),
        .rst    (rst),
        .load_i (last_w),
        .word_i (next_w),
        .res_o  (res_w),
        .vld_o  (byte_vld_o)
    );

    assign byte_o     = res_w.data;
    assign byte_par_o = res_w.par;
endmodule

// File: rtl/sbc_checker.sv
module sbc_checker
    import sbc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              bit_vld_i,
    input logic [WORD_W-1:0] byte_o,
    input logic              byte_vld_o,
    input logic              byte_par_o
);
    logic seen_rst;
    always_ff @(posedge clk) begin
        if (rst) seen_rst <= 1'b1;
        else if (seen_rst !== 1'b1) seen_rst <= 1'b0;
    end

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (byte_o == '0 && !byte_vld_o && !byte_par_o));

    assert_vld_after_accept_R2: assert property (@(posedge clk) disable iff (rst || seen_rst !== 1'b1)
        byte_vld_o |-> $past(bit_vld_i));

    assert_single_strobe_R4: assert property (@(posedge clk) disable iff (rst || seen_rst !== 1'b1)
        byte_vld_o |=> !byte_vld_o);

    assert_even_parity_R5: assert property (@(posedge clk) disable iff (rst || seen_rst !== 1'b1)
        byte_vld_o |-> (byte_par_o == (^byte_o)));

    assert_hold_R6: assert property (@(posedge clk) disable iff (rst || seen_rst !== 1'b1)
        (!byte_vld_o && !$past(rst)) |-> ($stable(byte_o) && $stable(byte_par_o)));
endmodule

bind ser_byte_collector sbc_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .bit_vld_i  (bit_vld_i),
    .byte_o     (byte_o),
    .byte_vld_o (byte_vld_o),
    .byte_par_o (byte_par_o)
);

// File: tb/tb_ser_byte_collector.sv
`timescale 1ns/1ps
module tb_ser_byte_collector;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bit_i = 1'b0;
    logic       bit_vld_i = 1'b0;
    logic [7:0] byte_o;
    logic       byte_vld_o;
    logic       byte_par_o;

    int checks = 0;
    int failures = 0;
    int sent = 0;
    int got = 0;
    logic [7:0] exp_q[$];
    logic [7:0] last_byte = 8'h00;
    logic       last_par = 1'b0;
    logic       prev_vld = 1'b0;

    always #5 clk = ~clk;

    ser_byte_collector dut (
        .clk(clk), .rst(rst), .bit_i(bit_i), .bit_vld_i(bit_vld_i),
        .byte_o(byte_o), .byte_vld_o(byte_vld_o), .byte_par_o(byte_par_o)
    );

    function automatic logic ref_par(input logic [7:0] b);
        int ones = 0;
        for (int k = 0; k < 8; k++) if (b[k]) ones++;
        return (ones % 2) == 1;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Driver: push expectation, then drive bits LSB first with optional idle gaps.
    task automatic send_byte(input logic [7:0] b, input int gap);
        exp_q.push_back(b);
        sent++;
        for (int i = 0; i < 8; i++) begin
            if (gap > 0 && (i % 3) == 1) begin
                for (int g = 0; g < gap; g++) begin
                    bit_vld_i = 1'b0;
                    bit_i     = ~b[i];   // R2: junk while unqualified
                    @(negedge clk);
                end
            end
            bit_vld_i = 1'b1;
            bit_i     = b[i];
            @(negedge clk);
        end
        bit_vld_i = 1'b0;
        bit_i     = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            bit_vld_i = 1'b0;
            bit_i = i[0];
            @(negedge clk);
        end
    endtask

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (rst) begin
            last_byte = 8'h00;
            last_par  = 1'b0;
            prev_vld  = 1'b0;
        end else begin
            if (byte_vld_o) begin
                check(!prev_vld, "R4", "strobe longer than one cycle", 1, 0);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R4", "unexpected strobe", byte_o, 0);
                end else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    got++;
                    check(byte_o == e, "R3", "byte value", byte_o, e);
                    check(byte_par_o == ref_par(e), "R5", "parity bit",
                          byte_par_o, ref_par(e));
                end
                last_byte = byte_o;
                last_par  = byte_par_o;
            end else begin
                check(byte_o == last_byte && byte_par_o == last_par, "R6",
                      "output held between strobes", byte_o, last_byte);
            end
            prev_vld = byte_vld_o;
        end
    end

    initial begin
        #2_000_000;
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        check(byte_o == 8'h00 && !byte_vld_o && !byte_par_o, "R1",
              "reset state", {byte_vld_o, byte_par_o, byte_o}, 0);
        rst = 1'b0;
        idle(3);

        send_byte(8'h01, 0);   // R3: first bit lands at bit 0
        idle(4);
        send_byte(8'h80, 0);   // R3: eighth bit lands at bit 7
        idle(2);
        send_byte(8'hA5, 2);   // R2: gaps with inverted junk, even ones
        idle(3);
        send_byte(8'h07, 5);   // R2/R5: odd ones, long gaps
        idle(3);

        // R7: continuous stream, no idle between bytes
        send_byte(8'h3C, 0);
        send_byte(8'hFF, 0);
        send_byte(8'h00, 0);
        send_byte(8'hE1, 0);
        idle(3);

        // R1: abandon a partial byte with reset
        bit_vld_i = 1'b1;
        for (int i = 0; i < 3; i++) begin
            bit_i = 1'b1;
            @(negedge clk);
        end
        bit_vld_i = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check(byte_o == 8'h00 && !byte_vld_o && !byte_par_o, "R1",
              "cleared by mid-stream reset", byte_o, 0);
        rst = 1'b0;
        send_byte(8'h52, 0);   // R1: must not include the 3 abandoned bits
        idle(4);

        check(exp_q.size() == 0 && got == sent, "R7", "all bytes delivered",
              got, sent);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule